// File: doc/BRIEF.md
# One-Time-PROM Programming Port

This block is the on-chip side of the port through which an external programmer writes and checks the one-time program memory. There are no address pins. An internal word counter selects the cell, and the programmer moves it forward by pulsing a slow clock pin. Four mode pins choose one of four operations: clear the counter, write the byte on the data pins, read the stored byte back for verification, or inhibit all programming. The memory array is outside the block, which gives it an address, a byte of write data and a write strobe, and gets back its read data.

The mode pins and the data pins are registered on the system clock. The programming clock is synchronised through a parameterised flop chain and then edge-detected. A cluster counter counts completed programming-clock pulses. The word address moves up by one when the third pulse of each group of four ends. It stops at the last implemented word. The data pins are driven only in verify mode.

Top module: `otp_port`

## Requirements
- R1: The mode code {md[3],md[2],md[1],md[0]} = 4'b0101 clears the word address to 0.
- R2: Mode code 4'b1110 is write mode: mem_we is 1, mem_wdata carries d_in and mem_addr is the current word address.
- R3: Mode code 4'b1100 is verify mode: d_oe is 1 and d_out carries mem_rdata for the current word address.
- R4: Mode code 4'b1111 (inhibit) and every code not listed in R1 to R3 give mem_we = 0, d_oe = 0 and d_out = 0. Write takes priority over inhibit for 4'b1110.
- R5: Each group of four programming-clock pulses advances the address by one. The step happens when the third pulse of the group ends (its falling edge), so the address does not move after two pulses or on the fourth.
- R6: The address saturates at LAST_ADDR (default 1001, 3E9h). Further pulse groups leave it unchanged.
- R7: The clear code also resets the pulse cluster counter, so after a clear a new step needs three full pulses.
- R8: While rst_n is low, mem_addr is 0, mem_we is 0 and d_oe is 0. The mode register then reads as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_clk | input | 1 | Programming clock pin, asynchronous to clk |
| md | input | 4 | Mode pins, md[0] is the first mode pin |
| d_in | input | DATA_W | Data pins, input side |
| d_out | output | DATA_W | Data pins, output side (0 when not driven) |
| d_oe | output | 1 | Output enable of the data pins |
| mem_addr | output | ADDR_W | Word address to the memory array |
| mem_we | output | 1 | Write strobe to the memory array |
| mem_wdata | output | DATA_W | Write data to the memory array |
| mem_rdata | input | DATA_W | Read data from the memory array |

## Verification
A mode or data change shows at the memory side and the data pins one clock after it is sampled, and an address clear takes one clock more. A falling edge of the programming clock moves the address three clocks later: two synchroniser stages and the address register. The bench holds every programming-clock level for four clocks and then waits three more before it samples. It drives all inputs and samples all outputs on falling clock edges, so every result is read after its last register has updated. The checker times its address-clear property with a two-cycle `$past` on the mode pins.

// File: rtl/otp_port_pkg.sv
package otp_port_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_CLEAR,
      OP_WRITE,
      OP_VERIFY,
      OP_INHIBIT
   } op_e;

   // codes are {md3, md2, md1, md0}
   localparam logic [3:0] CODE_CLEAR  = 4'b0101;
   localparam logic [3:0] CODE_WRITE  = 4'b1110;
   localparam logic [3:0] CODE_VERIFY = 4'b1100;

   function automatic op_e decode_mode(input logic [3:0] code);
      op_e r;
      if (code == CODE_CLEAR)       r = OP_CLEAR;
      else if (code == CODE_WRITE)  r = OP_WRITE;   // wins over inhibit
      else if (code == CODE_VERIFY) r = OP_VERIFY;
      else if (code[3:1] == 3'b111) r = OP_INHIBIT;
      else                          r = OP_IDLE;
      return r;
   endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
   import otp_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        md,
   input  logic [DATA_W-1:0] d_in,
   output op_e               op_q,
   output logic [DATA_W-1:0] din_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= OP_IDLE;
         din_q <= '0;
      end else begin
         op_q  <= decode_mode(md);
         din_q <= d_in;
      end
   end

endmodule

// File: rtl/otp_step_ctr.sv
module otp_step_ctr #(
   parameter int ADDR_W      = 10,
   parameter int LAST_ADDR   = 1001,
   parameter int PULSES      = 4,
   parameter int ADV_PULSE   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pclk,
   input  logic              clear,
   output logic [ADDR_W-1:0] addr
);

   localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
   localparam logic [PW-1:0]     PCNT_WRAP = PW'(PULSES - 1);
   localparam logic [PW-1:0]     PCNT_ADV  = PW'(ADV_PULSE - 1);
   localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(LAST_ADDR);

   if (SYNC_STAGES < 1)
      $error("otp_step_ctr: SYNC_STAGES must be at least 1");
   if (PULSES < 2)
      $error("otp_step_ctr: PULSES must be at least 2");
   if (ADV_PULSE < 1 || ADV_PULSE > PULSES)
      $error("otp_step_ctr: ADV_PULSE out of range");
   if (LAST_ADDR >= (1 << ADDR_W))
      $error("otp_step_ctr: LAST_ADDR does not fit ADDR_W");

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pclk_s;
   logic                   pclk_d;
   logic                   fall;
   logic [PW-1:0]          pcnt;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= pclk;
      end
   end else begin : g_syncn
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], pclk};
      end
   end

   assign pclk_s = sync_q[SYNC_STAGES-1];
   assign fall   = pclk_d & ~pclk_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pclk_d <= 1'b0;
         pcnt   <= '0;
         addr   <= '0;
      end else begin
         pclk_d <= pclk_s;
         if (clear) begin
            pcnt <= '0;
            addr <= '0;
         end else if (fall) begin
            pcnt <= (pcnt == PCNT_WRAP) ? '0 : pcnt + 1'b1;
            if (pcnt == PCNT_ADV && addr != ADDR_LAST)
               addr <= addr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/otp_bus_ctl.sv
module otp_bus_ctl
   import otp_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] din_q,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              d_oe,
   output logic [DATA_W-1:0] d_out
);

   always_comb begin
      mem_we    = (op == OP_WRITE);
      mem_wdata = din_q;
      d_oe      = (op == OP_VERIFY);
      d_out     = d_oe ? mem_rdata : '0;
   end

endmodule

// File: rtl/otp_port.sv
module otp_port
   import otp_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 10,
   parameter int LAST_ADDR   = 1001,
   parameter int PULSES      = 4,
   parameter int ADV_PULSE   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_clk,
   input  logic [3:0]        md,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (DATA_W < 1)
      $error("otp_port: DATA_W must be positive");

   op_e               op_q;
   logic [DATA_W-1:0] din_q;

   otp_mode_dec #(.DATA_W(DATA_W)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .md    (md),
      .d_in  (d_in),
      .op_q  (op_q),
      .din_q (din_q)
   );

   otp_step_ctr #(
      .ADDR_W      (ADDR_W),
      .LAST_ADDR   (LAST_ADDR),
      .PULSES      (PULSES),
      .ADV_PULSE   (ADV_PULSE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .pclk  (prog_clk),
      .clear (op_q == OP_CLEAR),
      .addr  (mem_addr)
   );

   otp_bus_ctl #(.DATA_W(DATA_W)) u_bus (
      .op        (op_q),
      .din_q     (din_q),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .d_oe      (d_oe),
      .d_out     (d_out)
   );

endmodule

// File: rtl/otp_port_chk.sv
module otp_port_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 10,
   parameter int LAST_ADDR = 1001
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        md,
   input logic [DATA_W-1:0] d_in,
   input logic [DATA_W-1:0] d_out,
   input logic              d_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata
);

   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(md, 2) == 4'b0101 && $past(rst_n, 2)) |-> mem_addr == '0);

   assert_wdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(rst_n)) |-> mem_wdata == $past(d_in));

   assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      d_oe |-> d_out == mem_rdata);

   assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && d_oe));

   assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !d_oe |-> d_out == '0);

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr != $past(mem_addr)) |->
         (mem_addr == $past(mem_addr) + 1'b1 || mem_addr == '0));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr <= ADDR_W'(LAST_ADDR));

endmodule

bind otp_port otp_port_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .LAST_ADDR (LAST_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .md        (md),
   .d_in      (d_in),
   .d_out     (d_out),
   .d_oe      (d_oe),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata)
);

// File: tb/otp_port_test.sv
module otp_port_test;

   localparam int DW   = 8;
   localparam int AW   = 10;
   localparam int LAST = 1001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prog_clk = 1'b0;
   logic [3:0]    md = 4'b1111;
   logic [DW-1:0] d_in = '0;
   logic [DW-1:0] d_out;
   logic          d_oe;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;

   logic [DW-1:0] mem [0:(1<<AW)-1];

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   otp_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_clk  (prog_clk),
      .md        (md),
      .d_in      (d_in),
      .d_out     (d_out),
      .d_oe      (d_oe),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   // array model
   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) prog_clk = 1'b1;
         repeat (4) @(negedge clk);
         prog_clk = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   // {md, din, pulses, exp_addr, exp_we, exp_oe, exp_dout}
   localparam int NV = 18;
   localparam logic [35:0] VEC [NV] = '{
      {4'b0101, 8'h00, 4'd0, 10'd0, 1'b0, 1'b0, 8'h00}, // R1 clear
      {4'b1110, 8'hA5, 4'd0, 10'd0, 1'b1, 1'b0, 8'h00}, // R2 write
      {4'b1111, 8'h00, 4'd0, 10'd0, 1'b0, 1'b0, 8'h00}, // R4 inhibit
      {4'b1100, 8'h00, 4'd0, 10'd0, 1'b0, 1'b1, 8'hA5}, // R3 verify
      {4'b1111, 8'h00, 4'd2, 10'd0, 1'b0, 1'b0, 8'h00}, // R5 two pulses
      {4'b1111, 8'h00, 4'd1, 10'd1, 1'b0, 1'b0, 8'h00}, // R5 third pulse
      {4'b1111, 8'h00, 4'd1, 10'd1, 1'b0, 1'b0, 8'h00}, // R5 fourth pulse
      {4'b1110, 8'h3C, 4'd0, 10'd1, 1'b1, 1'b0, 8'h00}, // R2 write
      {4'b1111, 8'h00, 4'd0, 10'd1, 1'b0, 1'b0, 8'h00}, // R4
      {4'b1100, 8'h00, 4'd0, 10'd1, 1'b0, 1'b1, 8'h3C}, // R3
      {4'b1111, 8'h00, 4'd4, 10'd2, 1'b0, 1'b0, 8'h00}, // R5 full group
      {4'b1100, 8'h00, 4'd0, 10'd2, 1'b0, 1'b1, 8'h00}, // R3 blank cell
      {4'b1101, 8'hFF, 4'd0, 10'd2, 1'b0, 1'b0, 8'h00}, // R4 unlisted code
      {4'b1111, 8'h00, 4'd2, 10'd2, 1'b0, 1'b0, 8'h00}, // R7 partial group
      {4'b0101, 8'h00, 4'd0, 10'd0, 1'b0, 1'b0, 8'h00}, // R7 clear
      {4'b1111, 8'h00, 4'd2, 10'd0, 1'b0, 1'b0, 8'h00}, // R7 count restarted
      {4'b1111, 8'h00, 4'd1, 10'd1, 1'b0, 1'b0, 8'h00}, // R7 third pulse
      {4'b1100, 8'h00, 4'd0, 10'd1, 1'b0, 1'b1, 8'h3C}  // R3
   };

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog R5 actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      repeat (5) @(negedge clk);
      chk("R8 addr in reset", int'(mem_addr), 0);
      chk("R8 we in reset", int'(mem_we), 0);
      chk("R8 oe in reset", int'(d_oe), 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [35:0] e;
         e = VEC[v];
         @(negedge clk);
         md   = e[35:32];
         d_in = e[31:24];
         pulse(int'(e[23:20]));
         repeat (3) @(negedge clk);
         chk($sformatf("R1/R5 vec%0d addr", v), int'(mem_addr), int'(e[19:10]));
         chk($sformatf("R2 vec%0d we", v), int'(mem_we), int'(e[9]));
         chk($sformatf("R3 vec%0d oe", v), int'(d_oe), int'(e[8]));
         chk($sformatf("R3/R4 vec%0d dout", v), int'(d_out), int'(e[7:0]));
         if (e[9]) chk($sformatf("R2 vec%0d wdata", v), int'(mem_wdata), int'(e[31:24]));
      end

      // R6 saturation at the last word
      md = 4'b0101;
      repeat (3) @(negedge clk);
      md = 4'b1111;
      pulse(4 * LAST);
      repeat (3) @(negedge clk);
      chk("R6 reached last word", int'(mem_addr), LAST);
      pulse(8);
      repeat (3) @(negedge clk);
      chk("R6 held at last word", int'(mem_addr), LAST);

      // R8 reset mid-run in verify mode
      md = 4'b1100;
      repeat (3) @(negedge clk);
      chk("R3 oe at last word", int'(d_oe), 1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 addr after reset", int'(mem_addr), 0);
      chk("R8 oe after reset", int'(d_oe), 0);
      rst_n = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule